// File: doc/BRIEF.md
# Capture/Reload Timer with Serial Clock Steering

This block is a 16-bit up-counter with a byte-wide control register and a 16-bit capture/reload register. The counter advances on an internal enable that fires once every twelve system clocks, or on falling edges of an external count pin. A falling edge on a separate trigger pin can either snapshot the counter or force a reload. Which one happens depends on the control byte.

The timer has three operating styles. In capture style, overflow wraps the counter to zero and trigger edges snapshot it. In reload style, overflow and, if enabled, trigger edges load the counter from the reload register. In baud style, the counter always reloads on overflow, the overflow flag stays clear, and trigger edges are ignored. The overflow pulses are steered to separate receive and transmit clock-select outputs. A serial port would use these as bit-rate ticks. When a direction is not assigned to this timer, that direction's output instead passes through an overflow pulse from another timer.

Software reaches the block through a simple write port. Address 0 is the control byte, address 1 is the counter and address 2 is the capture/reload register. All three registers are visible as outputs.

Top module: `tmr_capreload`

## Requirements
- R1: After reset the control byte, counter and capture/reload register are 0, and irq, ovf_pulse, rx_clk_pulse and tx_clk_pulse are 0.
- R2: With control bit 2 (run) set and bit 1 (ext_cnt) clear, the counter advances by exactly one per 12 clocks. With run clear and no trigger action, the counter holds.
- R3: With run and ext_cnt both set, the counter advances by one for each falling edge on cnt_pin.
- R4: In capture style (bit 0 cap_mode = 1, bits 5 and 4 clear), overflow from 0xFFFF gives 0x0000 and sets control bit 7 (ovf_flag).
- R5: In reload style (cap_mode = 0, bits 5 and 4 clear), overflow loads the counter from the capture/reload register and sets ovf_flag.
- R6: With cap_mode = 1, bit 3 (trig_en) = 1 and no baud style, a falling edge on trig_pin copies the counter into the capture/reload register and sets control bit 6 (ext_flag). Counting continues from the unchanged counter.
- R7: With cap_mode = 0, trig_en = 1 and no baud style, a falling edge on trig_pin loads the counter from the capture/reload register and sets ext_flag.
- R8: With trig_en = 0, trig_pin edges change neither the counter, the capture/reload register nor the control byte.
- R9: When bit 5 (rx_sel) or bit 4 (tx_sel) is set, cap_mode is ignored, every overflow reloads the counter, ovf_flag is never set, and trig_pin edges have no effect.
- R10: rx_clk_pulse carries this timer's overflow pulses when rx_sel = 1 and alt_ovf pulses when rx_sel = 0. tx_clk_pulse does the same under tx_sel. Each output lags its source by one clock.
- R11: ovf_flag and ext_flag are set only by the hardware events above. A control write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged.
- R12: irq is 1 exactly when ovf_flag or ext_flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 counter, 2 capture/reload |
| wr_data | input | 16 | Write data (control uses bits 7:0) |
| cnt_pin | input | 1 | External count input, falling edge counts |
| trig_pin | input | 1 | External trigger input, falling edge acts |
| alt_ovf | input | 1 | Overflow pulse from another timer |
| ctrl_q | output | 8 | Control byte |
| cnt_q | output | 16 | Counter value |
| rld_q | output | 16 | Capture/reload register |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | Registered overflow pulse |
| rx_clk_pulse | output | 1 | Receive clock select pulse |
| tx_clk_pulse | output | 1 | Transmit clock select pulse |

## Verification
The bench drives the counter to 0xFFFE and steps it across the wrap in each style. A design that mixed up wrap-to-zero and reload, or that raised the overflow flag in baud style, would show the wrong counter value or a stray bit 7. Trigger edges are applied with the enable off and in baud style. This catches a design that snapshots or reloads when it should not. The capture check confirms that the counter keeps counting from its old value afterwards, rather than being disturbed by the snapshot. Flag writes of 1 and of 0 show whether software can wrongly set a flag, and the receive and transmit outputs are counted under each steering choice to catch swapped or unrouted pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_sel;
    logic tx_sel;
    logic trig_en;
    logic run;
    logic ext_cnt;
    logic cap_mode;
  } tmr_ctrl_t;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_RLD  = 2'd2
  } tmr_addr_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  // R3: a single edge yields one detect cycle
  a_r3_single_fall: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12,
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || div_q == W'(DIV-1)) div_q <= '0;
    else                            div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == W'(DIV-1));

  // R2: enable is one cycle wide
  a_r2_tick_once: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             pre_tick,
  input  logic             cnt_fall,
  input  logic             trig_fall,
  output tmr_ctrl_t        ctrl,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld,
  output logic             ovf_now
);
  tmr_ctrl_t wr_ctrl;
  logic wr_c, wr_n, wr_r;
  logic baud, tick, ext_evt, cap_evt, rld_evt;

  always_comb begin
    wr_ctrl = tmr_ctrl_t'(wr_data[7:0]);
    wr_c    = wr_en && (wr_addr == ADDR_CTRL);
    wr_n    = wr_en && (wr_addr == ADDR_CNT);
    wr_r    = wr_en && (wr_addr == ADDR_RLD);
    baud    = ctrl.rx_sel | ctrl.tx_sel;
    tick    = ctrl.run & (ctrl.ext_cnt ? cnt_fall : pre_tick);
    ovf_now = tick & (cnt == '1);
    ext_evt = trig_fall & ctrl.trig_en & ~baud;
    cap_evt = ext_evt & ctrl.cap_mode;
    rld_evt = ext_evt & ~ctrl.cap_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_n) begin
      cnt <= wr_data;
    end else if (rld_evt) begin
      cnt <= rld;
    end else if (ovf_now) begin
      cnt <= (baud || !ctrl.cap_mode) ? rld : '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rld <= '0;
    else if (wr_r)    rld <= wr_data;
    else if (cap_evt) rld <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (wr_c) begin
        ctrl.rx_sel   <= wr_ctrl.rx_sel;
        ctrl.tx_sel   <= wr_ctrl.tx_sel;
        ctrl.trig_en  <= wr_ctrl.trig_en;
        ctrl.run      <= wr_ctrl.run;
        ctrl.ext_cnt  <= wr_ctrl.ext_cnt;
        ctrl.cap_mode <= wr_ctrl.cap_mode;
      end
      ctrl.ovf_flag <= ((wr_c ? wr_ctrl.ovf_flag : 1'b1) & ctrl.ovf_flag)
                       | (ovf_now & ~baud);
      ctrl.ext_flag <= ((wr_c ? wr_ctrl.ext_flag : 1'b1) & ctrl.ext_flag)
                       | ext_evt;
    end
  end

  // R2: stopped counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !rld_evt && !wr_n) |=> $stable(cnt));
  // R4 / R11: overflow flag rises only from a non-baud overflow
  a_r4_ovf_src: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.ovf_flag) |-> $past(ovf_now && !baud));
  // R9: baud style never raises the overflow flag
  a_r9_no_flag: assert property (@(posedge clk) disable iff (rst)
    (baud && !ctrl.ovf_flag) |=> !ctrl.ovf_flag);
  // R11: external flag rises only from a qualified trigger edge
  a_r11_ext_src: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl.ext_flag) |-> $past(ext_evt));
  // R8: a disabled trigger leaves the capture register alone
  a_r8_no_cap: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.trig_en && !wr_r) |=> $stable(rld));
endmodule

// File: rtl/tmr_capreload.sv
module tmr_capreload
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_DIV  = 12,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             cnt_pin,
  input  logic             trig_pin,
  input  logic             alt_ovf,
  output logic [7:0]       ctrl_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             irq,
  output logic             ovf_pulse,
  output logic             rx_clk_pulse,
  output logic             tx_clk_pulse
);
  tmr_ctrl_t ctrl;
  logic pre_tick, cnt_fall, trig_fall, ovf_now;

  tmr_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(pre_tick));

  tmr_edge_sync #(.STAGES(SYNC_STG)) u_cnt_sync (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(cnt_fall));

  tmr_edge_sync #(.STAGES(SYNC_STG)) u_trig_sync (
    .clk(clk), .rst(rst), .pin(trig_pin), .fall(trig_fall));

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pre_tick(pre_tick), .cnt_fall(cnt_fall),
    .trig_fall(trig_fall), .ctrl(ctrl), .cnt(cnt_q), .rld(rld_q),
    .ovf_now(ovf_now));

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_pulse    <= 1'b0;
      rx_clk_pulse <= 1'b0;
      tx_clk_pulse <= 1'b0;
    end else begin
      ovf_pulse    <= ovf_now;
      rx_clk_pulse <= ctrl.rx_sel ? ovf_now : alt_ovf;
      tx_clk_pulse <= ctrl.tx_sel ? ovf_now : alt_ovf;
    end
  end

  assign ctrl_q = ctrl;
  assign irq    = ctrl.ovf_flag | ctrl.ext_flag;

  // R10: own overflow reaches the selected direction
  a_r10_rx_own: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl.rx_sel) && ovf_pulse) |-> rx_clk_pulse);
  a_r10_tx_own: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl.tx_sel) && ovf_pulse) |-> tx_clk_pulse);
endmodule

// File: tb/sim_tmr_capreload.sv
module sim_tmr_capreload;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cnt_pin = 1'b1;
  logic        trig_pin = 1'b1;
  logic        alt_ovf = 1'b0;
  logic [7:0]  ctrl_q;
  logic [15:0] cnt_q, rld_q;
  logic        irq, ovf_pulse, rx_clk_pulse, tx_clk_pulse;

  int checks = 0;
  int failures = 0;
  int rx_seen = 0;
  int tx_seen = 0;
  bit done = 1'b0;

  tmr_capreload u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .alt_ovf(alt_ovf), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .rld_q(rld_q),
    .irq(irq), .ovf_pulse(ovf_pulse), .rx_clk_pulse(rx_clk_pulse),
    .tx_clk_pulse(tx_clk_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rx_clk_pulse) rx_seen++;
    if (tx_clk_pulse) tx_seen++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_cnt(int n);
    for (int i = 0; i < n; i++) begin
      cnt_pin = 1'b0; repeat (4) @(negedge clk);
      cnt_pin = 1'b1; repeat (4) @(negedge clk);
    end
  endtask

  task automatic pulse_trig();
    trig_pin = 1'b0; repeat (4) @(negedge clk);
    trig_pin = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic pulse_alt(int n);
    for (int i = 0; i < n; i++) begin
      alt_ovf = 1'b1; @(negedge clk);
      alt_ovf = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_q, 8'h00);
    check("R1 cnt", cnt_q, 16'h0);
    check("R1 rld", rld_q, 16'h0);
    check("R1 outs", {irq, ovf_pulse, rx_clk_pulse, tx_clk_pulse}, 4'b0);
  endtask

  task automatic t_internal();
    logic [15:0] a;
    wr(0, 16'h0004);
    repeat (5) @(negedge clk);
    a = cnt_q;
    repeat (120) @(negedge clk);
    check("R2 internal rate", cnt_q - a, 16'd10);
    wr(0, 16'h0000);
    a = cnt_q;
    repeat (50) @(negedge clk);
    check("R2 hold", cnt_q, a);
  endtask

  task automatic t_external();
    wr(1, 16'h0000);
    wr(0, 16'h0006);
    pulse_cnt(5);
    check("R3 ext count", cnt_q, 16'd5);
  endtask

  task automatic t_wrap();
    wr(0, 16'h0007);
    wr(2, 16'h4321);
    wr(1, 16'hFFFE);
    pulse_cnt(2);
    check("R4 wrap to zero", cnt_q, 16'h0000);
    check("R4 ovf flag", ctrl_q, 8'h87);
    check("R12 irq on ovf", irq, 1'b1);
    wr(0, 16'h00C7);
    check("R11 write 1 keeps, no set", ctrl_q, 8'h87);
    wr(0, 16'h0007);
    check("R11 write 0 clears", ctrl_q, 8'h07);
    check("R12 irq low", irq, 1'b0);
  endtask

  task automatic t_reload();
    wr(0, 16'h0006);
    wr(2, 16'h1234);
    wr(1, 16'hFFFF);
    pulse_cnt(1);
    check("R5 reload on ovf", cnt_q, 16'h1234);
    check("R5 ovf flag", ctrl_q[7], 1'b1);
    wr(0, 16'h0006);
  endtask

  task automatic t_capture();
    wr(0, 16'h000F);
    wr(1, 16'h0100);
    pulse_cnt(3);
    pulse_trig();
    check("R6 captured", rld_q, 16'h0103);
    check("R6 ext flag", ctrl_q, 8'h4F);
    check("R12 irq on ext", irq, 1'b1);
    pulse_cnt(1);
    check("R6 count continues", cnt_q, 16'h0104);
    wr(0, 16'h000F);
  endtask

  task automatic t_trig_reload();
    wr(0, 16'h000E);
    wr(2, 16'h5555);
    wr(1, 16'h0010);
    pulse_trig();
    check("R7 trig reload", cnt_q, 16'h5555);
    check("R7 ext flag", ctrl_q, 8'h4E);
    wr(0, 16'h0006);
  endtask

  task automatic t_trig_ignored();
    wr(1, 16'h0020);
    pulse_trig();
    check("R8 cnt unchanged", cnt_q, 16'h0020);
    check("R8 rld unchanged", rld_q, 16'h5555);
    check("R8 ctrl unchanged", ctrl_q, 8'h06);
    wr(0, 16'h0007);
    pulse_trig();
    check("R8 no capture", rld_q, 16'h5555);
    check("R8 ctrl cap", ctrl_q, 8'h07);
  endtask

  task automatic t_baud();
    wr(0, 16'h002F);
    wr(2, 16'hFFFE);
    wr(1, 16'hFFFE);
    rx_seen = 0; tx_seen = 0;
    pulse_cnt(2);
    check("R9 reload in baud", cnt_q, 16'hFFFE);
    check("R9 no ovf flag", ctrl_q, 8'h2F);
    check("R10 rx own pulse", rx_seen, 1);
    check("R10 tx from alt", tx_seen, 0);
    pulse_trig();
    check("R9 trig ignored cnt", cnt_q, 16'hFFFE);
    check("R9 trig ignored flags", ctrl_q, 8'h2F);
    pulse_cnt(4);
    check("R10 rx count", rx_seen, 3);
    check("R9 irq stays low", irq, 1'b0);
  endtask

  task automatic t_alt();
    wr(0, 16'h0000);
    rx_seen = 0; tx_seen = 0;
    pulse_alt(3);
    check("R10 rx alt", rx_seen, 3);
    check("R10 tx alt", tx_seen, 3);
    wr(0, 16'h0010);
    rx_seen = 0; tx_seen = 0;
    pulse_alt(2);
    check("R10 rx alt with tx_sel", rx_seen, 2);
    check("R10 tx own only", tx_seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_internal();
    t_external();
    t_wrap();
    t_reload();
    t_capture();
    t_trig_reload();
    t_trig_ignored();
    t_baud();
    t_alt();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule